// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block turns parallel characters into an asynchronous serial line stream. A character is written into a one-entry holding stage. When the output shifter is idle, the character moves into the shifter one clock later. The shifter then sends a frame made of a low start bit, the data bits with the least significant first, an optional parity bit and one or two high stop bits. A clock divisor sets the length of each bit. The holding stage accepts the next character while the current one is still on the line, so the line can carry frames back to back.

Three status outputs report the state. The ready flag shows that the holding stage is free. The empty flag shows that the shifter is idle. A sticky overrun flag records a write made while the holding stage was still full. A break input holds the line low at any time without disturbing the frame timing underneath. The data width, the stop-bit count, the parity mode and the divisor source (a port or a constant) are elaboration parameters.

Top module: `serial_tx_dbuf`

## Requirements
- R1: After reset, txd is 1, tx_ready is 1, tx_empty is 1 and tx_overrun is 0.
- R2: A cycle with wr_en high makes tx_ready 0 from the next cycle. If the shifter is idle, tx_ready returns to 1 one cycle after that, when the character has moved into the shifter.
- R3: A frame is a start bit of 0, then DATA_W data bits with bit 0 first, then the parity bit if one is configured, then the stop bits of 1. Each bit lasts divisor+1 clock cycles. The divisor is sampled when the character enters the shifter, so a change during a frame affects only later frames.
- R4: With even parity, the parity bit is the XOR of the data bits. With odd parity, it is the inverse of that XOR. With no parity, the frame carries no parity bit.
- R5: tx_empty is 0 from the cycle after a load until the last stop bit has lasted its full period, and 1 at all other times.
- R6: A character written while the shifter is busy waits in the holding stage. tx_ready stays 0 until that character is loaded. The load happens one clock after the shifter goes idle, so exactly one idle-high cycle separates the two frames.
- R7: A write while tx_ready is 0 sets tx_overrun and replaces the held character. tx_overrun stays set until a cycle with ovr_clr high and no such write. If both happen in the same cycle, the set wins.
- R8: While brk is 1, txd is 0 in the same cycle. The frame timing and the status outputs carry on as if brk were 0, and the line returns to the frame's current level when brk falls.
- R9: STOP_BITS selects one or two stop bits, and DATA_W may be 7, 8 or 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the holding stage |
| wr_data | input | DATA_W | Character to send |
| divisor | input | 16 | Bit period minus one, in clock cycles |
| brk | input | 1 | Force the line low |
| ovr_clr | input | 1 | Clear the overrun flag |
| txd | output | 1 | Serial output, idle high |
| tx_ready | output | 1 | Holding stage free |
| tx_empty | output | 1 | Shifter idle |
| tx_overrun | output | 1 | Sticky overrun flag |

## Verification
An error in the holding stage shows on tx_ready or tx_overrun within one clock of the write that exposes it. A lost or duplicated load shows as a tx_empty edge in the wrong cycle. An error in the bit counter or the divisor latch shifts a txd edge within one bit period. The comparison runs on every clock, so a fault shows in the first cycle where its effect reaches a port. The bench runs three parameter sets side by side so that each parity mode, both stop-bit counts and all three widths are covered.

// File: rtl/tx_dbuf_pkg.sv
package tx_dbuf_pkg;
    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ODD  = 2'd2
    } parity_e;

    localparam int DIV_W = 16;
endpackage

// File: rtl/tx_hold_reg.sv
module tx_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    input  logic              ovr_clr,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_full,
    output logic              overrun
);
    typedef struct packed {
        logic              full;
        logic              ovr;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.full = 1'b0;
        end
        if (wr_en) begin
            st_d.data = wr_data;
            st_d.full = 1'b1;
        end
        // a write that finds the stage occupied sets the flag; set beats clear
        if (wr_en && st_q.full) begin
            st_d.ovr = 1'b1;
        end else if (ovr_clr) begin
            st_d.ovr = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_data = st_q.data;
    assign hold_full = st_q.full;
    assign overrun   = st_q.ovr;
endmodule

// File: rtl/tx_baud_gen.sv
module tx_baud_gen #(
    parameter int          DIV_W         = 16,
    parameter bit          DIV_FROM_PORT = 1'b1,
    parameter logic [15:0] DIV_CONST     = 16'd3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div_in,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] lim;
    } baud_t;

    baud_t            st_d, st_q;
    logic [DIV_W-1:0] div_sel;

    generate
        if (DIV_FROM_PORT) begin : g_div_port
            assign div_sel = div_in;
        end else begin : g_div_const
            assign div_sel = DIV_W'(DIV_CONST);
        end
    endgenerate

    assign tick = run && (st_q.cnt == st_q.lim);

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.cnt = '0;
            st_d.lim = div_sel;
        end else if (run) begin
            st_d.cnt = tick ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tx_frame_shift.sv
module tx_frame_shift
    import tx_dbuf_pkg::*;
#(
    parameter int      DATA_W    = 8,
    parameter int      STOP_BITS = 1,
    parameter parity_e PARITY    = PAR_EVEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              tick,
    output logic              busy,
    output logic              line
);
    localparam int PAR_W   = (PARITY == PAR_NONE) ? 0 : 1;
    localparam int FRAME_W = 1 + DATA_W + PAR_W + STOP_BITS;
    localparam int IDX_W   = $clog2(FRAME_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

    typedef struct packed {
        logic               busy;
        logic [IDX_W-1:0]   idx;
        logic [FRAME_W-1:0] frame;
    } shift_t;

    shift_t             st_d, st_q;
    logic [FRAME_W-1:0] built;

    generate
        if (PAR_W == 1) begin : g_par
            logic par_bit;
            assign par_bit = (PARITY == PAR_ODD) ? ~(^load_data) : ^load_data;
            assign built   = {{STOP_BITS{1'b1}}, par_bit, load_data, 1'b0};
        end else begin : g_nopar
            assign built   = {{STOP_BITS{1'b1}}, load_data, 1'b0};
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.busy  = 1'b1;
            st_d.idx   = '0;
            st_d.frame = built;
        end else if (st_q.busy && tick) begin
            st_d.frame = {1'b1, st_q.frame[FRAME_W-1:1]};
            if (st_q.idx == LAST_IDX) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;
    assign line = st_q.busy ? st_q.frame[0] : 1'b1;
endmodule

// File: rtl/serial_tx_dbuf.sv
module serial_tx_dbuf
    import tx_dbuf_pkg::*;
#(
    parameter int          DATA_W        = 8,
    parameter int          STOP_BITS     = 1,
    parameter parity_e     PARITY        = PAR_EVEN,
    parameter bit          DIV_FROM_PORT = 1'b1,
    parameter logic [15:0] DIV_CONST     = 16'd3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [15:0]       divisor,
    input  logic              brk,
    input  logic              ovr_clr,
    output logic              txd,
    output logic              tx_ready,
    output logic              tx_empty,
    output logic              tx_overrun
);
    logic [DATA_W-1:0] hold_data;
    logic              hold_full;
    logic              sh_busy;
    logic              sh_line;
    logic              load;
    logic              tick;

    // holding stage drains one clock after the shifter is seen idle
    assign load = hold_full && !sh_busy;

    tx_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .take      (load),
        .ovr_clr   (ovr_clr),
        .hold_data (hold_data),
        .hold_full (hold_full),
        .overrun   (tx_overrun)
    );

    tx_baud_gen #(
        .DIV_W         (DIV_W),
        .DIV_FROM_PORT (DIV_FROM_PORT),
        .DIV_CONST     (DIV_CONST)
    ) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load),
        .run     (sh_busy),
        .div_in  (divisor),
        .tick    (tick)
    );

    tx_frame_shift #(
        .DATA_W    (DATA_W),
        .STOP_BITS (STOP_BITS),
        .PARITY    (PARITY)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (hold_data),
        .tick      (tick),
        .busy      (sh_busy),
        .line      (sh_line)
    );

    assign txd        = brk ? 1'b0 : sh_line;
    assign tx_ready   = !hold_full;
    assign tx_empty   = !sh_busy;
endmodule

// File: rtl/tx_dbuf_checker.sv
module tx_dbuf_checker (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic brk,
    input logic ovr_clr,
    input logic txd,
    input logic tx_ready,
    input logic tx_empty,
    input logic tx_overrun
);
    assert_write_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !tx_ready);

    assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(tx_empty) && !brk) |-> !txd);

    assert_idle_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty && !brk) |-> txd);

    assert_prompt_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_ready && tx_empty) |=> !tx_empty);

    assert_ovr_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !tx_ready) |=> tx_overrun);

    assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_overrun && !ovr_clr) |=> tx_overrun);
endmodule

bind serial_tx_dbuf tx_dbuf_checker u_tx_dbuf_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .brk        (brk),
    .ovr_clr    (ovr_clr),
    .txd        (txd),
    .tx_ready   (tx_ready),
    .tx_empty   (tx_empty),
    .tx_overrun (tx_overrun)
);

// File: tb/test_serial_tx_dbuf.sv
module tx_ref_model #(
    parameter int DATA_W    = 8,
    parameter int STOP_BITS = 1,
    parameter int PAR_MODE  = 1  // 0 none, 1 even, 2 odd
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [8:0]  data,
    input  logic [15:0] divisor,
    input  logic        brk,
    input  logic        clr,
    output logic        e_txd,
    output logic        e_ready,
    output logic        e_empty,
    output logic        e_ovr
);
    int   bits[$];
    int   held;
    bit   held_valid;
    bit   ovr;
    bit   sending;
    int   period;
    int   elapsed;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits.delete();
            held = 0; held_valid = 0; ovr = 0; sending = 0;
            period = 1; elapsed = 0;
        end else begin
            bit was_full;
            was_full = held_valid;
            if (sending) begin
                if (elapsed == period - 1) begin
                    void'(bits.pop_front());
                    elapsed = 0;
                    if (bits.size() == 0) sending = 0;
                end else begin
                    elapsed++;
                end
            end else if (was_full) begin
                int ones;
                ones = 0;
                bits.push_back(0);
                for (int i = 0; i < DATA_W; i++) begin
                    bits.push_back((held >> i) & 1);
                    ones += (held >> i) & 1;
                end
                if (PAR_MODE == 1) bits.push_back(ones % 2);
                if (PAR_MODE == 2) bits.push_back(1 - (ones % 2));
                for (int s = 0; s < STOP_BITS; s++) bits.push_back(1);
                period = int'(divisor) + 1;
                elapsed = 0;
                sending = 1;
                held_valid = 0;
            end
            if (wr) begin
                held = int'(data) & ((1 << DATA_W) - 1);
                held_valid = 1;
            end
            if (wr && was_full) ovr = 1;
            else if (clr) ovr = 0;
        end
    end

    assign e_txd   = brk ? 1'b0 : (sending ? bits[0][0] : 1'b1);
    assign e_ready = !held_valid;
    assign e_empty = !sending;
    assign e_ovr   = ovr;
endmodule

module test_serial_tx_dbuf;
    import tx_dbuf_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [8:0]  data = '0;
    logic [15:0] divisor = 16'd3;
    logic        brk = 1'b0;
    logic        clr = 1'b0;

    int    n_checks = 0;
    int    n_fails  = 0;
    string phase    = "R1";
    bit    done     = 1'b0;

    always #2 clk = ~clk;

    logic a_txd, a_rdy, a_emp, a_ovr, ea_txd, ea_rdy, ea_emp, ea_ovr;
    logic b_txd, b_rdy, b_emp, b_ovr, eb_txd, eb_rdy, eb_emp, eb_ovr;
    logic c_txd, c_rdy, c_emp, c_ovr, ec_txd, ec_rdy, ec_emp, ec_ovr;

    serial_tx_dbuf #(.DATA_W(8), .STOP_BITS(1), .PARITY(PAR_EVEN)) i_serial_tx_dbuf (
        .clk(clk), .rst_n(rst_n), .wr_en(wr), .wr_data(data[7:0]), .divisor(divisor),
        .brk(brk), .ovr_clr(clr), .txd(a_txd), .tx_ready(a_rdy), .tx_empty(a_emp),
        .tx_overrun(a_ovr));
    tx_ref_model #(.DATA_W(8), .STOP_BITS(1), .PAR_MODE(1)) m_a (
        .clk(clk), .rst_n(rst_n), .wr(wr), .data(data), .divisor(divisor), .brk(brk),
        .clr(clr), .e_txd(ea_txd), .e_ready(ea_rdy), .e_empty(ea_emp), .e_ovr(ea_ovr));

    serial_tx_dbuf #(.DATA_W(7), .STOP_BITS(2), .PARITY(PAR_ODD)) i_serial_tx_dbuf_odd (
        .clk(clk), .rst_n(rst_n), .wr_en(wr), .wr_data(data[6:0]), .divisor(divisor),
        .brk(brk), .ovr_clr(clr), .txd(b_txd), .tx_ready(b_rdy), .tx_empty(b_emp),
        .tx_overrun(b_ovr));
    tx_ref_model #(.DATA_W(7), .STOP_BITS(2), .PAR_MODE(2)) m_b (
        .clk(clk), .rst_n(rst_n), .wr(wr), .data(data), .divisor(divisor), .brk(brk),
        .clr(clr), .e_txd(eb_txd), .e_ready(eb_rdy), .e_empty(eb_emp), .e_ovr(eb_ovr));

    serial_tx_dbuf #(.DATA_W(9), .STOP_BITS(1), .PARITY(PAR_NONE)) i_serial_tx_dbuf_np (
        .clk(clk), .rst_n(rst_n), .wr_en(wr), .wr_data(data), .divisor(divisor),
        .brk(brk), .ovr_clr(clr), .txd(c_txd), .tx_ready(c_rdy), .tx_empty(c_emp),
        .tx_overrun(c_ovr));
    tx_ref_model #(.DATA_W(9), .STOP_BITS(1), .PAR_MODE(0)) m_c (
        .clk(clk), .rst_n(rst_n), .wr(wr), .data(data), .divisor(divisor), .brk(brk),
        .clr(clr), .e_txd(ec_txd), .e_ready(ec_rdy), .e_empty(ec_emp), .e_ovr(ec_ovr));

    task automatic check(string req, string what, logic got, logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s %s at %0t: got %b expected %b", req, what, $time, got, exp);
        end
    endtask

    // per-clock comparison against the reference model, away from the edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(phase, "A txd (R3 R4 R8)", a_txd, ea_txd);
            check(phase, "A ready (R2 R6)", a_rdy, ea_rdy);
            check(phase, "A empty (R5)", a_emp, ea_emp);
            check(phase, "A overrun (R7)", a_ovr, ea_ovr);
            check(phase, "B txd (R4 R9)", b_txd, eb_txd);
            check(phase, "B ready", b_rdy, eb_rdy);
            check(phase, "B empty", b_emp, eb_emp);
            check(phase, "B overrun", b_ovr, eb_ovr);
            check(phase, "C txd (R4 R9)", c_txd, ec_txd);
            check(phase, "C ready", c_rdy, ec_rdy);
            check(phase, "C empty", c_emp, ec_emp);
            check(phase, "C overrun", c_ovr, ec_ovr);
        end
    end

    task automatic put(logic [8:0] d);
        @(posedge clk); #1;
        wr = 1'b1; data = d;
        @(posedge clk); #1;
        wr = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        idle(3);
        #1;
        // R1: state straight after reset
        check("R1", "txd", a_txd, 1'b1);
        check("R1", "tx_ready", a_rdy, 1'b1);
        check("R1", "tx_empty", a_emp, 1'b1);
        check("R1", "tx_overrun", a_ovr, 1'b0);
        rst_n = 1'b1;
        idle(2);

        phase = "R2 R3";
        put(9'h0A5);
        idle(60);

        phase = "R4";
        put(9'h000); idle(55);
        put(9'h1FF); idle(55);
        put(9'h001); idle(55);
        put(9'h16E); idle(55);

        phase = "R6";
        put(9'h03C);
        idle(6);
        put(9'h181);
        idle(120);

        phase = "R7";
        put(9'h011);
        put(9'h022);
        idle(3);
        @(posedge clk); #1; clr = 1'b1;
        @(posedge clk); #1; clr = 1'b0;
        idle(110);
        put(9'h044);
        put(9'h055);
        @(posedge clk); #1; wr = 1'b1; clr = 1'b1; data = 9'h066;
        @(posedge clk); #1; wr = 1'b0; clr = 1'b0;
        idle(150);

        phase = "R8";
        put(9'h0F0);
        idle(9);
        brk = 1'b1;
        idle(10);
        brk = 1'b0;
        idle(60);
        brk = 1'b1;
        idle(5);
        brk = 1'b0;
        idle(5);

        phase = "R3 divisor";
        divisor = 16'd0;
        put(9'h0C3); idle(20);
        put(9'h13C); idle(2);
        put(9'h099); idle(30);
        divisor = 16'd7;
        put(9'h05A);
        idle(20);
        divisor = 16'd2;
        idle(110);
        put(9'h0A6);
        idle(45);

        phase = "R9";
        put(9'h07F); idle(1);
        put(9'h100); idle(80);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule